// File: doc/BRIEF.md
# Delayed Priority Interrupt Arbiter

This block keeps interrupt requests waiting across eight priority levels, each request carrying an 8-bit vector number. At every instruction boundary signalled by the core it compares the waiting requests against the core's current priority. It then tells the core, one cycle later, to take an interrupt and which vector and level to use. Saving the program counter and status word and fetching from the vector address stay in the core.

A countdown of instruction boundaries sits between a request becoming visible and the interrupt being taken. Any waiting request starts the countdown, even one whose level is not above the current priority. A request can be taken only on the boundary where the countdown runs out. Every accepted interrupt restarts the countdown, so further waiting requests are spaced out by the same number of boundaries. A status output shows whether an eligible request is waiting. It stays low while more than one boundary of the countdown is left.

Top module: `irq_delay_arbiter`

## Requirements
- R1: A waiting request is eligible only when its level is strictly greater than `cur_prio`. The output `take_level` is always above the `cur_prio` sampled at the boundary that caused the take.
- R2: When several levels hold eligible requests, the lowest-numbered eligible level is served first.
- R3: Within a level, the numerically smallest waiting vector is served first and is then removed. A request whose vector already waits in that level is absorbed and is not stored a second time.
- R4: The countdown changes only on a boundary. On each boundary where it holds a value above 1, it decreases by one and nothing is taken.
- R5: On a boundary where the countdown holds 1 and an eligible request waits, that request is taken.
- R6: On a boundary where the countdown holds 0 or 1 and no request is taken, the countdown is loaded with `INIT_DELAY` if any request waits at any level, eligible or not. Otherwise it goes to 0. After an accepted interrupt it is reloaded with `INIT_DELAY`.
- R7: `pending` is high when an eligible request waits and the countdown holds 1 or less. It is low otherwise.
- R8: Each level stores up to `DEPTH` (default 8) distinct vectors. A new vector arriving at a full level is dropped, and `overflow` then stays high until reset.
- R9: Reset empties every level, sets the countdown to 0, and clears `take`, `pending` and `overflow`.
- R10: A request presented on the same clock edge as a boundary is stored, but it is not seen by that boundary's scan. Its vector is tested for duplicates and for room against the store as it stood before that edge.
- R11: `take` is a one-cycle pulse in the cycle after the boundary edge that accepted the interrupt. During that cycle `take_vector` and `take_level` hold the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A new request is presented this cycle |
| req_level | input | 3 | Priority level of the new request |
| req_vector | input | 8 | Vector number of the new request |
| cur_prio | input | 3 | Current processor priority (status word bits 7:5) |
| insn_boundary | input | 1 | One-cycle strobe at each instruction boundary |
| take | output | 1 | Take an interrupt (one-cycle pulse) |
| take_vector | output | 8 | Vector of the accepted request |
| take_level | output | 3 | Level of the accepted request |
| pending | output | 1 | Eligible request waiting and countdown at 1 or less |
| overflow | output | 1 | Sticky: a request was dropped because its level was full |

## Verification
Storing a new request and serving a boundary can happen on the same edge, and both may target the same level. The request may also repeat the very vector being removed, or arrive at a level that is full before the removal. The bench provokes these cases directly and also by random traffic with a small vector range, so that duplicates and full levels occur often. It judges them against a behavioural model that decides the duplicate and room questions on the store as it was before the edge, and hides the new entry from that edge's scan.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int LEVELS = 8;
  localparam int LVL_W  = $clog2(LEVELS);
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqd_level_store.sv
module irqd_level_store #(
  parameter int DEPTH = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [VEC_W-1:0] push_vec,
  input  logic             pop_en,
  output logic             nonempty,
  output logic [VEC_W-1:0] min_vec,
  output logic             dropped
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic [VEC_W-1:0] slot_q [DEPTH];

  logic          present, free_found, min_found, do_write;
  logic [IW-1:0] free_idx, min_idx;

  // search: duplicate, first free slot, smallest stored vector
  always_comb begin
    present    = 1'b0;
    free_found = 1'b0;
    free_idx   = '0;
    min_found  = 1'b0;
    min_idx    = '0;
    min_vec    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && (slot_q[i] == push_vec)) present = 1'b1;
      if (!valid_q[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
      if (valid_q[i] && (!min_found || (slot_q[i] < min_vec))) begin
        min_found = 1'b1;
        min_idx   = IW'(i);
        min_vec   = slot_q[i];
      end
    end
  end

  assign nonempty = |valid_q;
  assign do_write = push_en && !present && free_found;
  assign dropped  = push_en && !present && !free_found;

  always_comb begin
    valid_d = valid_q;
    if (pop_en && min_found) valid_d[min_idx] = 1'b0;
    if (do_write)            valid_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (do_write) slot_q[free_idx] <= push_vec;
  end
endmodule

// File: rtl/irqd_scan.sv
module irqd_scan
  import irqd_pkg::*;
(
  input  logic [LEVELS-1:0] nonempty,
  input  lvl_t              cur_prio,
  output logic              any_pend,
  output logic              elig_found,
  output lvl_t              elig_lvl
);
  always_comb begin
    any_pend   = |nonempty;
    elig_found = 1'b0;
    elig_lvl   = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (nonempty[l] && (LVL_W'(l) > cur_prio) && !elig_found) begin
        elig_found = 1'b1;
        elig_lvl   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/irqd_delay.sv
module irqd_delay #(
  parameter int INIT = 2,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          any_pend,
  input  logic          elig,
  output logic          fire,
  output logic          gate_open,
  output logic [CW-1:0] count
);
  logic [CW-1:0] count_d;
  logic          count_en;

  assign fire      = boundary && (count == CW'(1)) && elig;
  assign gate_open = (count <= CW'(1));
  assign count_en  = boundary;

  always_comb begin
    if (count > CW'(1))  count_d = count - CW'(1);
    else if (any_pend)   count_d = CW'(INIT);
    else                 count_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/irq_delay_arbiter.sv
module irq_delay_arbiter
  import irqd_pkg::*;
#(
  parameter int INIT_DELAY = 2,
  parameter int DEPTH      = 8,
  parameter int VEC_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_level,
  input  logic [VEC_W-1:0] req_vector,
  input  logic [2:0]       cur_prio,
  input  logic             insn_boundary,
  output logic             take,
  output logic [VEC_W-1:0] take_vector,
  output logic [2:0]       take_level,
  output logic             pending,
  output logic             overflow
);
  localparam int CNT_W = $clog2(INIT_DELAY + 1);

  logic [LEVELS-1:0] nonempty, dropped;
  logic [VEC_W-1:0]  lvl_min [LEVELS];
  logic              any_pend, elig_found, fire, gate_open;
  lvl_t              elig_lvl;
  logic [CNT_W-1:0]  dly_count;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    irqd_level_store #(.DEPTH(DEPTH), .VEC_W(VEC_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (req_valid && (req_level == LVL_W'(g))),
      .push_vec (req_vector),
      .pop_en   (fire && (elig_lvl == LVL_W'(g))),
      .nonempty (nonempty[g]),
      .min_vec  (lvl_min[g]),
      .dropped  (dropped[g])
    );
  end

  irqd_scan u_scan (
    .nonempty   (nonempty),
    .cur_prio   (cur_prio),
    .any_pend   (any_pend),
    .elig_found (elig_found),
    .elig_lvl   (elig_lvl)
  );

  irqd_delay #(.INIT(INIT_DELAY), .CW(CNT_W)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (insn_boundary),
    .any_pend  (any_pend),
    .elig      (elig_found),
    .fire      (fire),
    .gate_open (gate_open),
    .count     (dly_count)
  );

  assign pending = elig_found && gate_open;

  logic             take_d, ovf_d;
  logic [VEC_W-1:0] vec_d;
  lvl_t             lvl_d;

  always_comb begin
    take_d = fire;
    ovf_d  = overflow | (|dropped);
    vec_d  = take_vector;
    lvl_d  = take_level;
    if (fire) begin
      vec_d = lvl_min[elig_lvl];
      lvl_d = elig_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take        <= 1'b0;
      overflow    <= 1'b0;
      take_vector <= '0;
      take_level  <= '0;
    end else begin
      take     <= take_d;
      overflow <= ovf_d;
      if (fire) begin
        take_vector <= vec_d;
        take_level  <= lvl_d;
      end
    end
  end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int INIT = 2,
  parameter int CW   = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_boundary,
  input logic [2:0]    cur_prio,
  input logic          take,
  input logic [2:0]    take_level,
  input logic          pending,
  input logic          overflow,
  input logic [CW-1:0] dly_count
);
  p_take_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_level > $past(cur_prio)));
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_boundary |=> $stable(dly_count));
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dly_count <= CW'(INIT));
  p_reload_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (dly_count == CW'(INIT)));
  p_pending_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_count > CW'(1)) |-> !pending);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_take_after_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_boundary));
endmodule

bind irq_delay_arbiter irqd_checker #(.INIT(INIT_DELAY), .CW(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .insn_boundary (insn_boundary),
  .cur_prio      (cur_prio),
  .take          (take),
  .take_level    (take_level),
  .pending       (pending),
  .overflow      (overflow),
  .dly_count     (dly_count)
);

// File: tb/sim_irq_delay_arbiter.sv
module sim_irq_delay_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int INIT       = 2;
  localparam int DEPTH      = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_level;
  logic [7:0] req_vector;
  logic [2:0] cur_prio;
  logic       insn_boundary;
  logic       take, pending, overflow;
  logic [7:0] take_vector;
  logic [2:0] take_level;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_delay_arbiter #(.INIT_DELAY(INIT), .DEPTH(DEPTH), .VEC_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_vector(req_vector), .cur_prio(cur_prio), .insn_boundary(insn_boundary),
    .take(take), .take_vector(take_vector), .take_level(take_level),
    .pending(pending), .overflow(overflow)
  );

  // behavioural reference model
  int q [8][$];
  int m_cnt;
  bit m_take, m_ovf;
  int m_vec, m_lvl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 8; l++) q[l].delete();
      m_cnt = 0; m_take = 0; m_ovf = 0; m_vec = 0; m_lvl = 0;
    end else begin
      bit any, ef, present, fire;
      int el, rl;
      any = 0; ef = 0; el = 0; present = 0; fire = 0;
      for (int l = 0; l < 8; l++)
        if (q[l].size() > 0) begin
          any = 1;
          if (!ef && l > int'(cur_prio)) begin ef = 1; el = l; end
        end
      rl = int'(req_level);
      if (req_valid)
        foreach (q[rl][i]) if (q[rl][i] == int'(req_vector)) present = 1;
      m_take = 0;
      if (insn_boundary) begin
        fire = (m_cnt == 1) && ef;
        if (fire) begin
          int mi;
          mi = 0;
          foreach (q[el][i]) if (q[el][i] < q[el][mi]) mi = i;
          m_vec = q[el][mi]; m_lvl = el; m_take = 1;
          q[el].delete(mi);
        end
        if (m_cnt > 1) m_cnt = m_cnt - 1;
        else           m_cnt = any ? INIT : 0;
      end
      if (req_valid && !present) begin
        if (q[rl].size() + ((fire && el == rl) ? 1 : 0) >= DEPTH) m_ovf = 1;
        else q[rl].push_back(int'(req_vector));
      end
    end
  end

  function automatic bit exp_pending();
    bit ef;
    ef = 0;
    for (int l = 0; l < 8; l++)
      if (q[l].size() > 0 && l > int'(cur_prio)) ef = 1;
    return ef && (m_cnt <= 1);
  endfunction

  task automatic compare();
    checks++;
    if (take !== m_take) begin
      errors++;
      $display("FAIL R1,R4,R5,R6,R11 take: actual=%0b expected=%0b", take, m_take);
    end
    if (m_take) begin
      checks++;
      if (take_vector !== 8'(m_vec)) begin
        errors++;
        $display("FAIL R3,R10 take_vector: actual=%0h expected=%0h", take_vector, m_vec);
      end
      checks++;
      if (take_level !== 3'(m_lvl)) begin
        errors++;
        $display("FAIL R2 take_level: actual=%0d expected=%0d", take_level, m_lvl);
      end
    end
    checks++;
    if (pending !== exp_pending()) begin
      errors++;
      $display("FAIL R7 pending: actual=%0b expected=%0b", pending, exp_pending());
    end
    checks++;
    if (overflow !== m_ovf) begin
      errors++;
      $display("FAIL R8 overflow: actual=%0b expected=%0b", overflow, m_ovf);
    end
  endtask

  // compare the previous cycle's result, then drive the next cycle
  task automatic cyc(input bit b, input bit v, input int l, input int vec);
    @(negedge clk);
    compare();
    insn_boundary = b;
    req_valid     = v;
    req_level     = 3'(l);
    req_vector    = 8'(vec);
  endtask

  task automatic idle_bounds(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
    end
  endtask

  task automatic check_reset_outputs();
    checks++;
    if (take !== 0 || pending !== 0 || overflow !== 0) begin
      errors++;
      $display("FAIL R9 reset outputs: actual=%0b%0b%0b expected=000", take, pending, overflow);
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_level = 0; req_vector = 0;
    cur_prio = 0; insn_boundary = 0;
    repeat (3) @(negedge clk);
    check_reset_outputs(); // R9
    rst_n = 1;
    // R5, R11: single request, counted down from an inactive counter
    cyc(0, 1, 5, 8'h40);
    idle_bounds(4);
    // R3: smallest vector first, duplicate absorbed
    cyc(0, 1, 3, 8'h30); cyc(0, 1, 3, 8'h10); cyc(0, 1, 3, 8'h20); cyc(0, 1, 3, 8'h10);
    idle_bounds(10);
    // R2: lowest eligible level first; R1: level 1 not above prio 1
    cur_prio = 3'd1;
    cyc(0, 1, 6, 8'h66); cyc(0, 1, 2, 8'h22); cyc(0, 1, 1, 8'h11);
    idle_bounds(8);
    // R6, R7: ineligible request still runs the counter
    cur_prio = 3'd7;
    idle_bounds(5);
    cur_prio = 3'd0;
    idle_bounds(4);
    // R8: fill level 4 beyond capacity
    cur_prio = 3'd7;
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 1, 4, 8'h80 + i);
    cyc(0, 1, 4, 8'h80);
    // R10: push on boundary edges, into the level being served
    cur_prio = 3'd3;
    for (int i = 0; i < 12; i++) cyc(1, 1, 4, 8'h80 + (i % 3));
    idle_bounds(20);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) cur_prio = 3'($urandom_range(0, 7));
      cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0),
          $urandom_range(0, 7), $urandom_range(0, 11));
    end
    // R9: reset in the middle of traffic
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check_reset_outputs();
    rst_n = 1;
    cur_prio = 3'd0;
    idle_bounds(3);
    cyc(0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule